// File: doc/BRIEF.md
# Monophonic MIDI Note Tracker

This block sits behind a serial MIDI receiver (31250 baud) and consumes one received byte each time its strobe is high. It follows the channel-voice traffic on the byte stream and keeps a single piece of state: the note most recently pressed and whether that note is still held. The result drives a monophonic oscillator and its gate. The note number is a 7-bit value and a separate flag tells the oscillator whether any note is sounding.

Only key-press and key-release messages change the state, and the block answers on every channel. The last channel status byte is remembered, so a controller that omits repeated status bytes (running status) is still understood. A key-press whose velocity is zero counts as a release, because many keyboards send releases that way. Every other message is still framed by its byte count so that later messages stay aligned, but it leaves the outputs alone. Real-time bytes can appear anywhere, even inside a message, and are skipped without disturbing anything.

Top module: `midi_note_tracker`

## Requirements
- R1: After a synchronous reset, `note_active` is 0 and `note_num` is 0.
- R2: A key-press (status high nibble 0x9, any channel in the low nibble) followed by key byte K and velocity byte V with V nonzero sets `note_active` to 1 and `note_num` to K on the clock edge that samples V. Before V arrives, the outputs are unchanged.
- R3: A key-release (status high nibble 0x8, any channel) for key K clears `note_active` only when a note is held and K equals `note_num`. A release for any other key has no effect. `note_num` keeps its value when the flag clears.
- R4: A key-press with velocity 0 behaves exactly like a key-release for the same key.
- R5: Data bytes that arrive without a fresh status byte are decoded with the last channel status received (running status).
- R6: Bytes 0xF8 to 0xFF change no output, running status or message position, even when they fall between the key and velocity bytes.
- R7: Other channel statuses (high nibble 0xA, 0xB or 0xE take two data bytes; 0xC or 0xD take one data byte) are consumed, including under running status, with no effect on the outputs.
- R8: Bytes 0xF0 to 0xF7 cancel running status. Data bytes are then discarded until the next channel status byte arrives. Data bytes received after reset but before any channel status are also discarded.
- R9: A new key-press replaces the held note, even while another note is still held.
- R10: A channel status byte that arrives in the middle of a message abandons the partial message. The next data byte is taken as the first data byte of the new message.
- R11: A status byte never changes the outputs on the edge that samples it, and the outputs do not change on any edge where the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | High for one cycle per received byte |
| byte_data | input | 8 | Received byte, valid while `byte_valid` is high |
| note_active | output | 1 | 1 while a note is held, 0 for no note |
| note_num | output | 7 | Most recent note number (registered) |

## Verification
On every cycle, the assertions check the following:
- The outputs hold still when there is no strobe, on status bytes and on real-time bytes.
- The flag rises only on a nonzero data byte.
- A release never alters the note number.
- A system-common byte always drops running status.

Only the bench's byte sequences can show the rest:
- Running status decodes correctly.
- A release must match the held key.
- A zero-velocity press acts as a release.
- One- and two-byte messages are framed correctly.
- Data is discarded after a system-common byte.
- A status byte arriving mid-message restarts the framing.

// File: rtl/midi_trk_pkg.sv
package midi_trk_pkg;
  typedef enum logic [1:0] {
    BK_DATA   = 2'd0,
    BK_CHAN   = 2'd1,
    BK_SYSCOM = 2'd2,
    BK_RTIME  = 2'd3
  } byte_kind_e;

  localparam logic [3:0] CMD_RELEASE = 4'h8;
  localparam logic [3:0] CMD_PRESS   = 4'h9;
endpackage

// File: rtl/midi_byte_classify.sv
module midi_byte_classify
  import midi_trk_pkg::*;
(
  input  logic [4:0]  top5,
  output byte_kind_e  kind,
  output logic        one_data
);
  always_comb begin
    if (!top5[4])                kind = BK_DATA;
    else if (top5[4:1] != 4'hF)  kind = BK_CHAN;
    else if (top5[0])            kind = BK_RTIME;
    else                         kind = BK_SYSCOM;
  end

  // Channel nibbles 0xC and 0xD carry a single data byte.
  assign one_data = (top5[4:2] == 3'b110);
endmodule

// File: rtl/midi_msg_parser.sv
module midi_msg_parser
  import midi_trk_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              msg_done,
  output logic [3:0]        msg_cmd,
  output logic [BYTE_W-2:0] msg_key,
  output logic [BYTE_W-2:0] msg_vel
);
  localparam int HI = BYTE_W - 1;
  localparam int PW = BYTE_W - 1;

  byte_kind_e     kind;
  logic           one_data;
  logic [3:0]     cmd_q;
  logic           one_q;
  logic           run_ok_q;
  logic           second_q;
  logic [PW-1:0]  key_q;

  midi_byte_classify cls_i (
    .top5     (in_byte[HI -: 5]),
    .kind     (kind),
    .one_data (one_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      one_q    <= 1'b0;
      run_ok_q <= 1'b0;
      second_q <= 1'b0;
      key_q    <= '0;
    end else if (in_valid) begin
      case (kind)
        BK_CHAN: begin
          cmd_q    <= in_byte[HI -: 4];
          one_q    <= one_data;
          run_ok_q <= 1'b1;
          second_q <= 1'b0;
        end
        BK_SYSCOM: begin
          run_ok_q <= 1'b0;
          second_q <= 1'b0;
        end
        BK_RTIME: ;
        default: begin
          if (run_ok_q) begin
            if (one_q)          second_q <= 1'b0;
            else if (!second_q) begin
              key_q    <= in_byte[PW-1:0];
              second_q <= 1'b1;
            end else            second_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign msg_done = in_valid && (kind == BK_DATA) && run_ok_q && (one_q || second_q);
  assign msg_cmd  = cmd_q;
  assign msg_key  = one_q ? in_byte[PW-1:0] : key_q;
  assign msg_vel  = in_byte[PW-1:0];

  p_syscom_cancels_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == BK_SYSCOM) |=> !run_ok_q);

  p_rtime_keeps_position_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == BK_RTIME) |=> ($stable(second_q) && $stable(run_ok_q) && $stable(cmd_q)));
endmodule

// File: rtl/midi_note_hold.sv
module midi_note_hold
  import midi_trk_pkg::*;
#(
  parameter int NOTE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_done,
  input  logic [3:0]        msg_cmd,
  input  logic [NOTE_W-1:0] msg_key,
  input  logic [NOTE_W-1:0] msg_vel,
  output logic              note_active,
  output logic [NOTE_W-1:0] note_num
);
  logic vel_zero;
  logic press_hit;
  logic release_hit;

  assign vel_zero    = (msg_vel == '0);
  assign press_hit   = msg_done && (msg_cmd == CMD_PRESS) && !vel_zero;
  assign release_hit = msg_done && note_active && (msg_key == note_num) &&
                       ((msg_cmd == CMD_RELEASE) || (msg_cmd == CMD_PRESS && vel_zero));

  always_ff @(posedge clk) begin
    if (rst) begin
      note_active <= 1'b0;
      note_num    <= '0;
    end else if (press_hit) begin
      note_active <= 1'b1;
      note_num    <= msg_key;
    end else if (release_hit) begin
      note_active <= 1'b0;
    end
  end

  p_release_keeps_num_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(note_active) |-> $stable(note_num));

  p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
    !msg_done |=> ($stable(note_active) && $stable(note_num)));
endmodule

// File: rtl/midi_note_tracker.sv
module midi_note_tracker #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              note_active,
  output logic [BYTE_W-2:0] note_num
);
  localparam int NOTE_W = BYTE_W - 1;

  logic              done;
  logic [3:0]        cmd;
  logic [NOTE_W-1:0] key;
  logic [NOTE_W-1:0] vel;

  midi_msg_parser #(.BYTE_W(BYTE_W)) parse_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (byte_valid),
    .in_byte  (byte_data),
    .msg_done (done),
    .msg_cmd  (cmd),
    .msg_key  (key),
    .msg_vel  (vel)
  );

  midi_note_hold #(.NOTE_W(NOTE_W)) hold_i (
    .clk         (clk),
    .rst         (rst),
    .msg_done    (done),
    .msg_cmd     (cmd),
    .msg_key     (key),
    .msg_vel     (vel),
    .note_active (note_active),
    .note_num    (note_num)
  );

  p_no_strobe_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> ($stable(note_active) && $stable(note_num)));

  p_status_no_effect_r11: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data[BYTE_W-1]) |=> ($stable(note_active) && $stable(note_num)));

  p_rtime_no_effect_r6: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data[BYTE_W-1 -: 5] == 5'b11111) |=> ($stable(note_active) && $stable(note_num)));

  p_set_needs_velocity_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(note_active) |-> ($past(byte_valid) && !$past(byte_data[BYTE_W-1]) &&
                            ($past(byte_data[NOTE_W-1:0]) != '0)));
endmodule

// File: tb/midi_note_tracker_tb_top.sv
module midi_note_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       note_active;
  logic [6:0] note_num;

  always #10 clk = ~clk;

  midi_note_tracker dut_i (
    .clk         (clk),
    .rst         (rst),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .note_active (note_active),
    .note_num    (note_num)
  );

  typedef struct {
    logic       act;
    logic [6:0] num;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  task automatic check(input logic a, input logic [6:0] n, input string tag);
    n_chk++;
    if (note_active !== a || note_num !== n) begin
      n_err++;
      $display("FAIL %s: active=%0b note=%02h expected active=%0b note=%02h",
               tag, note_active, note_num, a, n);
    end
  endtask

  // Driver: presents one byte, then queues the outputs expected after its edge.
  task automatic send(input logic [7:0] b, input logic ea, input logic [6:0] en,
                      input string tag);
    exp_t e;
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(posedge clk);
    #1;
    e.act = ea; e.num = en; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  // Monitor: compares the outputs after each strobed edge with the queued item.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.act, e.num, e.tag);
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: active=%0b note=%02h expected run to complete", note_active, note_num);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(1'b0, 7'h00, "R1 reset state");

    // R8: data with no status yet is discarded; R6 real-time at start
    send(8'h3C, 1'b0, 7'h00, "R8 data before status");
    send(8'h40, 1'b0, 7'h00, "R8 data before status");
    send(8'hF8, 1'b0, 7'h00, "R6 clock byte idle");

    // R2: press on channel 0
    send(8'h90, 1'b0, 7'h00, "R11 status no change");
    send(8'h3C, 1'b0, 7'h00, "R2 key without velocity");
    send(8'h64, 1'b1, 7'h3C, "R2 press sets note");
    repeat (4) @(posedge clk);
    #3 check(1'b1, 7'h3C, "R11 idle hold");

    // R5/R9: running status press replaces held note
    send(8'h40, 1'b1, 7'h3C, "R5 running key pending");
    send(8'h50, 1'b1, 7'h40, "R9 new press replaces");

    // R3: mismatched release ignored, matching release clears under running status
    send(8'h80, 1'b1, 7'h40, "R3 status");
    send(8'h3C, 1'b1, 7'h40, "R3 key");
    send(8'h00, 1'b1, 7'h40, "R3 mismatched release ignored");
    send(8'h40, 1'b1, 7'h40, "R5 running release key");
    send(8'h7F, 1'b0, 7'h40, "R3 matching release clears");

    // R6: real-time inside a message, channel 5
    send(8'h95, 1'b0, 7'h40, "R2 status ch5");
    send(8'h30, 1'b0, 7'h40, "R2 key ch5");
    send(8'hFE, 1'b0, 7'h40, "R6 sense byte mid message");
    send(8'hFA, 1'b0, 7'h40, "R6 start byte mid message");
    send(8'h20, 1'b1, 7'h30, "R6 framing kept after real-time");

    // R4: zero-velocity press as release (running status)
    send(8'h31, 1'b1, 7'h30, "R4 key");
    send(8'h00, 1'b1, 7'h30, "R4 zero vel other key ignored");
    send(8'h30, 1'b1, 7'h30, "R4 key");
    send(8'h00, 1'b0, 7'h30, "R4 zero vel press releases");

    // R7: one- and two-byte messages have no effect
    send(8'hC2, 1'b0, 7'h30, "R7 program status");
    send(8'h22, 1'b0, 7'h30, "R7 one-byte data");
    send(8'h23, 1'b0, 7'h30, "R7 one-byte running");
    send(8'hD0, 1'b0, 7'h30, "R7 pressure status");
    send(8'h24, 1'b0, 7'h30, "R7 pressure data");
    send(8'hB1, 1'b0, 7'h30, "R7 control status");
    send(8'h25, 1'b0, 7'h30, "R7 control data1");
    send(8'h26, 1'b0, 7'h30, "R7 control data2");
    send(8'hE0, 1'b0, 7'h30, "R7 bend status");
    send(8'h27, 1'b0, 7'h30, "R7 bend data1");
    send(8'h28, 1'b0, 7'h30, "R7 bend data2");

    // R8: system common cancels running status
    send(8'h90, 1'b0, 7'h30, "R8 press status");
    send(8'h50, 1'b0, 7'h30, "R8 key");
    send(8'h60, 1'b1, 7'h50, "R8 press");
    send(8'hF2, 1'b1, 7'h50, "R8 syscom");
    send(8'h51, 1'b1, 7'h50, "R8 data dropped");
    send(8'h61, 1'b1, 7'h50, "R8 running cancelled");
    send(8'hF6, 1'b1, 7'h50, "R8 syscom tune");
    send(8'h50, 1'b1, 7'h50, "R8 data dropped");
    send(8'h00, 1'b1, 7'h50, "R8 release dropped");
    send(8'h80, 1'b1, 7'h50, "R3 release status");
    send(8'h50, 1'b1, 7'h50, "R3 key");
    send(8'h00, 1'b0, 7'h50, "R3 release clears");

    // R10: status byte mid-message restarts framing
    send(8'h90, 1'b0, 7'h50, "R10 status");
    send(8'h61, 1'b0, 7'h50, "R10 partial key");
    send(8'h90, 1'b0, 7'h50, "R10 restart status");
    send(8'h62, 1'b0, 7'h50, "R10 new key is first byte");
    send(8'h01, 1'b1, 7'h62, "R10 new message decoded");

    repeat (4) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule